// File: doc/BRIEF.md
# Keyed Firmware Configuration Port

This block gives boot firmware a small window onto a set of configuration items. It has two bus-visible registers, told apart by a single address bit. A 16-bit control register takes a key that selects one item. A byte-wide data register then streams the selected item one byte per access. An internal offset advances on its own after each byte. Items live in two banks, a generic one and an architecture-local one, and the key picks the bank and the index within it.

A separate host-side load port fills the block before firmware runs. It writes bytes into a shared byte RAM and writes, for each entry, a base address into that RAM and a length. A length of zero marks an empty entry. Some keys open an item for writing through the same data register. When the last byte of such an item is written, a one-cycle completion strobe names the bank and index that were filled, and the offset returns to the start.

Top module: `kcfg_port`

## Requirements
- R1: Every accepted control write sets the byte offset to 0, whatever the key value.
- R2: A key whose index field (bits 13:0) is at or above NUM_ENT makes the selection invalid. Data reads then return 0x00 and data writes have no effect.
- R3: Key bit 15 selects the architecture-local bank (1) over the generic bank (0). The entry index is bits 13:0, with bits 15 and 14 masked off.
- R4: A data read returns 0x00 and leaves the offset unchanged when the selection is invalid, the entry length is 0, or the offset is at or past the length. Otherwise it returns the byte at base+offset and increments the offset. Read data appears on bus_rdata in the cycle after the access.
- R5: A data write is stored at base+offset and increments the offset only when key bit 14 (write channel) is set and the offset is below the entry length. Otherwise it is dropped.
- R6: An accepted write that brings the offset up to the length raises done_pulse for exactly one cycle, with done_bank and done_idx naming the entry, and sets the offset to 0.
- R7: While rst_n is low at a clock edge, the block behaves as if key 0x0000 had been written: offset 0, generic entry 0 selected. In addition, bus_rdata and done_pulse are 0 and every entry length is cleared to 0.
- R8: An item streams from increasing RAM addresses starting at its base, so an integer loaded least-significant byte first reads out in little-endian order.
- R9: The control register accepts only 16-bit writes (bus_wide=1). The data register accepts only byte accesses (bus_wide=0). Other access widths to these registers change nothing, not even bus_rdata. A read of the control register returns 0x00.
- R10: The host load port writes a byte into the RAM when ld_ram_we is high, and writes the base and length of entry (ld_ent_bank, ld_ent_idx) when ld_ent_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (key, or byte in bits 7:0) |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| ld_ram_we | input | 1 | Host byte write into the RAM |
| ld_ram_addr | input | RAM_AW | Host RAM address |
| ld_ram_data | input | 8 | Host RAM byte |
| ld_ent_we | input | 1 | Host descriptor write |
| ld_ent_bank | input | 1 | Descriptor bank (1 = architecture-local) |
| ld_ent_idx | input | IDX_W | Descriptor index |
| ld_ent_base | input | RAM_AW | Entry base address in the RAM |
| ld_ent_len | input | LEN_W | Entry length in bytes, 0 = empty |
| done_pulse | output | 1 | One-cycle write-completion strobe |
| done_bank | output | 1 | Bank of the completed entry |
| done_idx | output | IDX_W | Index of the completed entry |

## Verification
The main function is tried with short multi-byte reads in both banks under the same index, which shows whether bit 15 steers the bank. Reads that run past the end, reads of empty and out-of-range keys, and reselection in the middle of an item show whether the offset holds, returns to zero or advances as required. The write channel is tried with and without bit 14, up to the item length, past it and around the wrap, and each case is read back through a read-only key, so a stored byte, a dropped byte and the position of the offset are all visible. Accesses of the wrong width are placed between reads whose values would shift if those accesses had moved the offset or the read data.

// File: rtl/kcfg_pkg.sv
`timescale 1ns/1ps
// Shared key layout for the keyed configuration port.
// Assumes a 16-bit key: bank flag on top, write-channel flag below it,
// entry index in the remaining low bits.
package kcfg_pkg;
    localparam int KEY_W   = 16;
    localparam int FIELD_W = 14;

    typedef struct packed {
        logic               bank;   // 1 = architecture-local bank
        logic               wrch;   // 1 = write channel open
        logic [FIELD_W-1:0] idx;    // entry index field
    } key_t;
endpackage

// File: rtl/kcfg_keydec.sv
`timescale 1ns/1ps
// Splits a key into bank, write-channel flag and index, and flags
// whether the index names an existing entry.
// Assumes NUM_ENT >= 2 and NUM_ENT <= 2**14.
module kcfg_keydec #(
    parameter int NUM_ENT = 32,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  kcfg_pkg::key_t   key,
    output logic             valid,
    output logic             bank,
    output logic             wrch,
    output logic [IDX_W-1:0] idx
);
    // Decode the flags and range-check the index field.
    always_comb begin
        valid = (32'(key.idx) < NUM_ENT);
        bank  = key.bank;
        wrch  = key.wrch;
        idx   = key.idx[IDX_W-1:0];
    end
endmodule

// File: rtl/kcfg_desc_table.sv
`timescale 1ns/1ps
// Holds a base address and a length for each entry of both banks.
// Written only from the host load port; lengths clear on reset.
// Assumes the reader keeps rd_idx below NUM_ENT when it uses the result.
module kcfg_desc_table #(
    parameter int NUM_ENT = 32,
    parameter int IDX_W   = $clog2(NUM_ENT),
    parameter int RAM_AW  = 8,
    parameter int LEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic              ld_bank,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [RAM_AW-1:0] ld_base,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [RAM_AW-1:0] rd_base,
    output logic [LEN_W-1:0]  rd_len
);
    localparam int NBANK = 2;

    logic [RAM_AW-1:0] base_q [NBANK][NUM_ENT];
    logic [LEN_W-1:0]  len_q  [NBANK][NUM_ENT];
    logic              idx_ok;

    assign idx_ok = (32'(ld_idx) < NUM_ENT);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Store or clear the descriptors of one bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < NUM_ENT; e++) begin
                    len_q[b][e]  <= '0;
                    base_q[b][e] <= '0;
                end
            end else if (ld_we && idx_ok && (ld_bank == 1'(b))) begin
                base_q[b][ld_idx] <= ld_base;
                len_q[b][ld_idx]  <= ld_len;
            end
        end
    end

    // Look up the descriptor of the current selection.
    always_comb begin
        rd_base = base_q[rd_bank][rd_idx];
        rd_len  = len_q[rd_bank][rd_idx];
    end
endmodule

// File: rtl/kcfg_byte_ram.sv
`timescale 1ns/1ps
// Byte RAM shared by all entries: one write port, one asynchronous read.
// Assumes the caller has already arbitrated between its writers.
module kcfg_byte_ram #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write one byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the addressed byte.
    assign rdata = mem[raddr];
endmodule

// File: rtl/kcfg_port.sv
`timescale 1ns/1ps
// Keyed configuration port: a control register selects an entry by key,
// and a byte data register streams or fills it through an auto-advancing
// offset. A write that fills an open entry raises a one-cycle strobe.
// Assumes one bus access per strobe cycle, and no host RAM load in the
// same cycle as an accepted data write (the bus write wins).
module kcfg_port #(
    parameter int NUM_ENT   = 32,
    parameter int RAM_DEPTH = 256,
    parameter int LEN_W     = 8,
    parameter int RAM_AW    = $clog2(RAM_DEPTH),
    parameter int IDX_W     = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic              bus_wide,
    input  logic [15:0]       bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ld_ram_we,
    input  logic [RAM_AW-1:0] ld_ram_addr,
    input  logic [7:0]        ld_ram_data,
    input  logic              ld_ent_we,
    input  logic              ld_ent_bank,
    input  logic [IDX_W-1:0]  ld_ent_idx,
    input  logic [RAM_AW-1:0] ld_ent_base,
    input  logic [LEN_W-1:0]  ld_ent_len,
    output logic              done_pulse,
    output logic              done_bank,
    output logic [IDX_W-1:0]  done_idx
);
    // access decode
    logic ctl_wr, ctl_rd, dat_rd, dat_wr;
    // current selection and offset
    logic              sel_valid, sel_bank, sel_wrch;
    logic [IDX_W-1:0]  sel_idx;
    logic [LEN_W-1:0]  off_q, off_inc;
    // decoded key
    logic              k_valid, k_bank, k_wrch;
    logic [IDX_W-1:0]  k_idx;
    // entry descriptor and data path
    logic [RAM_AW-1:0] ent_base, byte_addr, ram_waddr;
    logic [LEN_W-1:0]  ent_len;
    logic [7:0]        ram_q, ram_wdata;
    logic              has_room, rd_ok, wr_ok, fill, ram_we;

    // Classify the bus access by register and width.
    always_comb begin
        ctl_wr = bus_req &  bus_we & ~bus_addr &  bus_wide;
        ctl_rd = bus_req & ~bus_we & ~bus_addr;
        dat_rd = bus_req & ~bus_we &  bus_addr & ~bus_wide;
        dat_wr = bus_req &  bus_we &  bus_addr & ~bus_wide;
    end

    kcfg_keydec #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_keydec (
        .key   (kcfg_pkg::key_t'(bus_wdata)),
        .valid (k_valid),
        .bank  (k_bank),
        .wrch  (k_wrch),
        .idx   (k_idx)
    );

    kcfg_desc_table #(
        .NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .RAM_AW(RAM_AW), .LEN_W(LEN_W)
    ) u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (ld_ent_we),
        .ld_bank (ld_ent_bank),
        .ld_idx  (ld_ent_idx),
        .ld_base (ld_ent_base),
        .ld_len  (ld_ent_len),
        .rd_bank (sel_bank),
        .rd_idx  (sel_idx),
        .rd_base (ent_base),
        .rd_len  (ent_len)
    );

    // Decide whether the current data access may touch the entry.
    always_comb begin
        off_inc   = off_q + 1'b1;
        has_room  = sel_valid && (ent_len != '0) && (off_q < ent_len);
        rd_ok     = dat_rd && has_room;
        wr_ok     = dat_wr && sel_wrch && has_room;
        fill      = wr_ok && (off_inc == ent_len);
        byte_addr = ent_base + RAM_AW'(off_q);
    end

    // Arbitrate the RAM write port between the bus and the host load.
    always_comb begin
        ram_we    = wr_ok | ld_ram_we;
        ram_waddr = wr_ok ? byte_addr : ld_ram_addr;
        ram_wdata = wr_ok ? bus_wdata[7:0] : ld_ram_data;
    end

    kcfg_byte_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (byte_addr),
        .rdata (ram_q)
    );

    // Latch the selection on a control write; reset selects key 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b1;
            sel_bank  <= 1'b0;
            sel_wrch  <= 1'b0;
            sel_idx   <= '0;
        end else if (ctl_wr) begin
            sel_valid <= k_valid;
            sel_bank  <= k_bank;
            sel_wrch  <= k_wrch;
            sel_idx   <= k_idx;
        end
    end

    // Track the byte offset: clear on select or fill, advance on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)              off_q <= '0;
        else if (ctl_wr || fill) off_q <= '0;
        else if (rd_ok || wr_ok) off_q <= off_inc;
    end

    // Register read data for both registers.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (dat_rd) bus_rdata <= rd_ok ? ram_q : 8'h00;
        else if (ctl_rd) bus_rdata <= 8'h00;
    end

    // Raise the completion strobe and name the filled entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse <= 1'b0;
            done_bank  <= 1'b0;
            done_idx   <= '0;
        end else begin
            done_pulse <= fill;
            if (fill) begin
                done_bank <= sel_bank;
                done_idx  <= sel_idx;
            end
        end
    end
endmodule

// File: rtl/kcfg_port_chk.sv
`timescale 1ns/1ps
// Property checker for kcfg_port, attached by bind below.
module kcfg_port_chk #(
    parameter int NUM_ENT = 32,
    parameter int LEN_W   = 8,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             dat_rd,
    input logic             dat_wr,
    input logic             rd_ok,
    input logic             wr_ok,
    input logic [15:0]      bus_wdata,
    input logic [LEN_W-1:0] off_q,
    input logic             sel_valid,
    input logic             sel_bank,
    input logic [IDX_W-1:0] sel_idx,
    input logic             done_pulse
);
    // R1
    sel_clears_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (off_q == '0));

    // R2
    bad_key_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (32'(bus_wdata[13:0]) >= NUM_ENT)) |=> !sel_valid);

    // R4
    rej_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !rd_ok) |=> $stable(off_q));

    // R4
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> (off_q == $past(off_q) + 1'b1));

    // R5
    rej_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !wr_ok) |=> $stable(off_q));

    // R6
    done_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (off_q == '0));

    // R6
    done_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(wr_ok));

    // R7
    reset_key0_chk: assert property (@(posedge clk)
        !rst_n |=> (off_q == '0 && sel_valid && !sel_bank && sel_idx == '0 && !done_pulse));
endmodule

bind kcfg_port kcfg_port_chk #(.NUM_ENT(NUM_ENT), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .dat_rd     (dat_rd),
    .dat_wr     (dat_wr),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok),
    .bus_wdata  (bus_wdata),
    .off_q      (off_q),
    .sel_valid  (sel_valid),
    .sel_bank   (sel_bank),
    .sel_idx    (sel_idx),
    .done_pulse (done_pulse)
);

// File: tb/kcfg_port_bench.sv
`timescale 1ns/1ps
module kcfg_port_bench;
    localparam int NUM_ENT = 32;
    localparam int RAM_AW  = 8;
    localparam int IDX_W   = 5;
    localparam int LEN_W   = 8;

    // vector ops
    localparam logic [2:0] OPC  = 3'd0; // 16-bit control write
    localparam logic [2:0] OPR  = 3'd1; // byte data read, check rdata
    localparam logic [2:0] OPW  = 3'd2; // byte data write, check done_pulse
    localparam logic [2:0] OPCB = 3'd3; // byte control write (ignored)
    localparam logic [2:0] OPRW = 3'd4; // 16-bit data read (ignored)
    localparam logic [2:0] OPCR = 3'd5; // control read, check rdata

    // {req[3:0], op[2:0], word[15:0], exp[7:0]}
    localparam int NV = 64;
    localparam logic [30:0] VEC [NV] = '{
        {4'd7,  OPR,  16'h0000, 8'hA1},
        {4'd10, OPR,  16'h0000, 8'hA2},
        {4'd8,  OPR,  16'h0000, 8'hA3},
        {4'd8,  OPR,  16'h0000, 8'hA4},
        {4'd4,  OPR,  16'h0000, 8'h00},
        {4'd3,  OPC,  16'h0003, 8'h00},
        {4'd8,  OPR,  16'h0000, 8'h34},
        {4'd9,  OPCB, 16'h0000, 8'h00},
        {4'd9,  OPR,  16'h0000, 8'h12},
        {4'd9,  OPCR, 16'h0000, 8'h00},
        {4'd4,  OPR,  16'h0000, 8'h00},
        {4'd3,  OPC,  16'h8003, 8'h00},
        {4'd3,  OPR,  16'h0000, 8'hB1},
        {4'd9,  OPRW, 16'h0000, 8'h00},
        {4'd9,  OPR,  16'h0000, 8'hB2},
        {4'd1,  OPC,  16'h8003, 8'h00},
        {4'd1,  OPR,  16'h0000, 8'hB1},
        {4'd3,  OPC,  16'h0003, 8'h00},
        {4'd3,  OPR,  16'h0000, 8'h34},
        {4'd2,  OPC,  16'h0020, 8'h00},
        {4'd2,  OPR,  16'h0000, 8'h00},
        {4'd3,  OPC,  16'h8003, 8'h00},
        {4'd3,  OPR,  16'h0000, 8'hB1},
        {4'd2,  OPC,  16'h3FFF, 8'h00},
        {4'd2,  OPR,  16'h0000, 8'h00},
        {4'd2,  OPC,  16'h7FFF, 8'h00},
        {4'd2,  OPW,  16'h0099, 8'h00},
        {4'd3,  OPC,  16'h0003, 8'h00},
        {4'd3,  OPR,  16'h0000, 8'h34},
        {4'd4,  OPC,  16'h0007, 8'h00},
        {4'd4,  OPR,  16'h0000, 8'h00},
        {4'd5,  OPC,  16'h0005, 8'h00},
        {4'd5,  OPW,  16'h0077, 8'h00},
        {4'd5,  OPC,  16'h0005, 8'h00},
        {4'd5,  OPR,  16'h0000, 8'h11},
        {4'd5,  OPC,  16'h4005, 8'h00},
        {4'd5,  OPW,  16'h00C1, 8'h00},
        {4'd5,  OPW,  16'h00C2, 8'h00},
        {4'd6,  OPW,  16'h00C3, 8'h01},
        {4'd5,  OPC,  16'h0005, 8'h00},
        {4'd5,  OPR,  16'h0000, 8'hC1},
        {4'd5,  OPR,  16'h0000, 8'hC2},
        {4'd5,  OPR,  16'h0000, 8'hC3},
        {4'd6,  OPC,  16'h4005, 8'h00},
        {4'd6,  OPW,  16'h00E1, 8'h00},
        {4'd6,  OPW,  16'h00E2, 8'h00},
        {4'd6,  OPW,  16'h00E3, 8'h01},
        {4'd6,  OPW,  16'h00D1, 8'h00},
        {4'd6,  OPC,  16'h0005, 8'h00},
        {4'd6,  OPR,  16'h0000, 8'hD1},
        {4'd6,  OPR,  16'h0000, 8'hE2},
        {4'd5,  OPC,  16'h4005, 8'h00},
        {4'd5,  OPR,  16'h0000, 8'hD1},
        {4'd5,  OPR,  16'h0000, 8'hE2},
        {4'd5,  OPR,  16'h0000, 8'hE3},
        {4'd5,  OPW,  16'h00EE, 8'h00},
        {4'd5,  OPR,  16'h0000, 8'h00},
        {4'd5,  OPC,  16'h0005, 8'h00},
        {4'd5,  OPR,  16'h0000, 8'hD1},
        {4'd5,  OPR,  16'h0000, 8'hE2},
        {4'd5,  OPR,  16'h0000, 8'hE3},
        {4'd4,  OPR,  16'h0000, 8'h00},
        {4'd9,  OPCR, 16'h0000, 8'h00},
        {4'd4,  OPR,  16'h0000, 8'h00}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0, bus_we = 1'b0, bus_addr = 1'b0, bus_wide = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              ld_ram_we = 1'b0;
    logic [RAM_AW-1:0] ld_ram_addr = '0;
    logic [7:0]        ld_ram_data = '0;
    logic              ld_ent_we = 1'b0, ld_ent_bank = 1'b0;
    logic [IDX_W-1:0]  ld_ent_idx = '0;
    logic [RAM_AW-1:0] ld_ent_base = '0;
    logic [LEN_W-1:0]  ld_ent_len = '0;
    logic              done_pulse, done_bank;
    logic [IDX_W-1:0]  done_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    kcfg_port #(.NUM_ENT(NUM_ENT)) u_kcfg_port (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_ram_we(ld_ram_we), .ld_ram_addr(ld_ram_addr), .ld_ram_data(ld_ram_data),
        .ld_ent_we(ld_ent_we), .ld_ent_bank(ld_ent_bank), .ld_ent_idx(ld_ent_idx),
        .ld_ent_base(ld_ent_base), .ld_ent_len(ld_ent_len),
        .done_pulse(done_pulse), .done_bank(done_bank), .done_idx(done_idx)
    );

    function automatic string rname(input int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp, input string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic access(input logic [2:0] op, input logic [15:0] word);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_wdata = word;
        case (op)
            OPC:     begin bus_we = 1; bus_addr = 0; bus_wide = 1; end
            OPR:     begin bus_we = 0; bus_addr = 1; bus_wide = 0; end
            OPW:     begin bus_we = 1; bus_addr = 1; bus_wide = 0; end
            OPCB:    begin bus_we = 1; bus_addr = 0; bus_wide = 0; end
            OPRW:    begin bus_we = 0; bus_addr = 1; bus_wide = 1; end
            default: begin bus_we = 0; bus_addr = 0; bus_wide = 1; end
        endcase
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic ld_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_ram_we = 1; ld_ram_addr = a; ld_ram_data = d;
        @(negedge clk);
        ld_ram_we = 0;
    endtask

    task automatic ld_ent(input logic b, input logic [4:0] i, input logic [7:0] base,
                          input logic [7:0] len);
        @(negedge clk);
        ld_ent_we = 1; ld_ent_bank = b; ld_ent_idx = i; ld_ent_base = base; ld_ent_len = len;
        @(negedge clk);
        ld_ent_we = 0;
    endtask

    task automatic load_desc();
        ld_ent(0, 0, 8'd0,  8'd4);
        ld_ent(0, 3, 8'd8,  8'd2);
        ld_ent(1, 3, 8'd16, 8'd3);
        ld_ent(0, 5, 8'd32, 8'd3);
        ld_ent(0, 7, 8'd40, 8'd0);
        ld_ent(1, 9, 8'd64, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state at the ports
        check("R7", bus_rdata, 0, "rdata after reset");
        check("R7", done_pulse, 0, "done after reset");
        rst_n = 1'b1;
        // R10 / R8: bytes loaded; 16-bit value 0x1234 stored low byte first
        ld_byte(0, 8'hA1); ld_byte(1, 8'hA2); ld_byte(2, 8'hA3); ld_byte(3, 8'hA4);
        ld_byte(8, 8'h34); ld_byte(9, 8'h12);
        ld_byte(16, 8'hB1); ld_byte(17, 8'hB2); ld_byte(18, 8'hB3);
        ld_byte(32, 8'h11); ld_byte(33, 8'h22); ld_byte(34, 8'h33);
        ld_byte(64, 8'h00);
        load_desc();

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            access(v[26:24], v[23:8]);
            if (v[26:24] == OPR || v[26:24] == OPCR)
                check(rname(int'(v[30:27])), bus_rdata, v[7:0], $sformatf("vector %0d rdata", i));
            else if (v[26:24] == OPW)
                check(rname(int'(v[30:27])), done_pulse, v[7:0], $sformatf("vector %0d done", i));
        end

        // R6: completion names the local-bank entry 9, then drops after one cycle
        access(OPC, 16'hC009);
        access(OPW, 16'h005A);
        check("R6", done_pulse, 1, "done on fill");
        check("R6", done_bank, 1, "done_bank");
        check("R6", done_idx, 9, "done_idx");
        @(negedge clk);
        check("R6", done_pulse, 0, "done one cycle only");
        access(OPC, 16'h8009);
        access(OPR, 16'h0000);
        check("R5", bus_rdata, 8'h5A, "written byte read back");

        // R7: reset in the middle of an item selects key 0 and clears lengths
        access(OPC, 16'h0003);
        access(OPR, 16'h0000);
        check("R3", bus_rdata, 8'h34, "before reset");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", bus_rdata, 0, "rdata cleared by reset");
        check("R7", done_pulse, 0, "done cleared by reset");
        rst_n = 1'b1;
        access(OPR, 16'h0000);
        check("R7", bus_rdata, 0, "lengths cleared by reset");
        load_desc();
        access(OPR, 16'h0000);
        check("R7", bus_rdata, 8'hA1, "key 0 selected at offset 0 after reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule